// File: doc/BRIEF.md
# Data-Cache Tag Checker

This block examines one tag entry read from a single way of a 4-way set-associative data cache. It takes the 32-bit upper tag word, the 64-bit lower tag word and the 13-bit set address used for the read. From these it decides whether the 5-bit coherence state is one of the encodings the cache can legally hold, and reduces that state to a compact 3-bit code. For a legal state it also checks the two parity bits that protect the physical address tag.

Alongside the checks, the block rebuilds the physical line address from the tag and the set address. It splits out the bank number and the set number, and it unpacks the replacement order into four way numbers. A diagnostic or scrubbing engine issues one tag on a `valid_i` strobe and reads every result one clock later.

Top module: `dtag_check`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `state_err_o` and `addr_err_o` are 0, `state_o` is 0, and `paddr_o`, `lru_way_o`, `bank_o` and `set_o` are all zero.
- R2: The state field is `tag_hi_i[29:25]`. It decodes to `state_o` as follows: 5'h00 gives 0 (invalid), 5'h0F gives 1 (coherent shared), 5'h13 gives 2 (non-coherent exclusive clean), 5'h19 gives 3 (non-coherent exclusive dirty), 5'h16 gives 4 (coherent exclusive clean) and 5'h1C gives 5 (coherent exclusive dirty). None of these raises `state_err_o`.
- R3: Any other state value sets `state_err_o` to 1 and `state_o` to 7.
- R4: When the state is illegal, `addr_err_o` is 0 whatever the parity bits hold.
- R5: For a legal state, `addr_err_o` is 1 when `tag_lo_i[11]` differs from the XOR of `tag_lo_i[39:26]`.
- R6: For a legal state, `addr_err_o` is 1 when `tag_lo_i[10]` differs from the XOR of `tag_lo_i[25:13]`. When both parity bits match, `addr_err_o` is 0.
- R7: `paddr_o` equals `{tag_lo_i[39:13], set_addr_i[12:0]}`. The other bits of `tag_lo_i` have no effect on it.
- R8: `lru_way_o[k]` equals `tag_hi_i[14+2k+1 : 14+2k]`. Index 0 is the least recently used way and index 3 is the most recently used way.
- R9: `bank_o` equals `{set_addr_i[12], set_addr_i[5]}` and `set_o` equals `set_addr_i[11:6]`.
- R10: Every result appears on the first rising clock edge after `valid_i` is sampled high. `valid_o` is high for exactly that one cycle for each strobe.
- R11: While `valid_i` is low, every output except `valid_o` keeps its value, even when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe marking one tag to check |
| tag_hi_i | input | 32 | Upper tag word: state and replacement order |
| tag_lo_i | input | 64 | Lower tag word: address tag and parity bits |
| set_addr_i | input | 13 | Set address used for the tag read |
| valid_o | output | 1 | Results updated this cycle |
| state_err_o | output | 1 | State encoding not legal |
| addr_err_o | output | 1 | Address tag parity mismatch (legal state only) |
| state_o | output | 3 | Decoded state code, 7 for illegal |
| paddr_o | output | 40 | Rebuilt physical line address |
| lru_way_o | output | 8 | Four 2-bit way numbers, LRU in [1:0], MRU in [7:6] |
| bank_o | output | 2 | Bank number |
| set_o | output | 6 | Set number within the bank |

## Verification
The assertions check three rules on every cycle. The address error and the state error never fire together. The state error agrees with the illegal state code. The outputs update only in the cycle after a strobe and hold otherwise. The values themselves can only be shown by the bench scenarios: the mapping of each of the six legal encodings, the parity ranges with a single flipped bit on each side, the address rebuilt with noisy unused tag bits, and the LRU and bank unpacking.

// File: rtl/dtag_pkg.sv
package dtag_pkg;
  typedef enum logic [2:0] {
    DST_INV  = 3'd0,
    DST_CSHR = 3'd1,
    DST_NCEC = 3'd2,
    DST_NCED = 3'd3,
    DST_CEC  = 3'd4,
    DST_CED  = 3'd5,
    DST_BAD  = 3'd7
  } dst_e;

  localparam logic [4:0] ENC_INV  = 5'h00;
  localparam logic [4:0] ENC_CSHR = 5'h0F;
  localparam logic [4:0] ENC_NCEC = 5'h13;
  localparam logic [4:0] ENC_NCED = 5'h19;
  localparam logic [4:0] ENC_CEC  = 5'h16;
  localparam logic [4:0] ENC_CED  = 5'h1C;
endpackage

// File: rtl/dtag_state_dec.sv
module dtag_state_dec
  import dtag_pkg::*;
#(
  parameter int ST_W = 5
) (
  input  logic [ST_W-1:0] st_i,
  output dst_e            code_o,
  output logic            legal_o
);
  always_comb begin
    legal_o = 1'b1;
    unique case (st_i)
      ENC_INV:  code_o = DST_INV;
      ENC_CSHR: code_o = DST_CSHR;
      ENC_NCEC: code_o = DST_NCEC;
      ENC_NCED: code_o = DST_NCED;
      ENC_CEC:  code_o = DST_CEC;
      ENC_CED:  code_o = DST_CED;
      default: begin
        code_o  = DST_BAD;
        legal_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/dtag_parity.sv
module dtag_parity #(
  parameter int TL_W   = 64,
  parameter int HI_MSB = 39,
  parameter int SPLIT  = 26,
  parameter int LO_LSB = 13,
  parameter int P1_BIT = 11,
  parameter int P0_BIT = 10
) (
  input  logic [TL_W-1:0] tag_lo_i,
  output logic            mism_hi_o,
  output logic            mism_lo_o
);
  logic sum_hi, sum_lo;

  // even parity over each tag slice, compared to its stored bit
  assign sum_hi    = ^tag_lo_i[HI_MSB:SPLIT];
  assign sum_lo    = ^tag_lo_i[SPLIT-1:LO_LSB];
  assign mism_hi_o = sum_hi ^ tag_lo_i[P1_BIT];
  assign mism_lo_o = sum_lo ^ tag_lo_i[P0_BIT];
endmodule

// File: rtl/dtag_lru_dec.sv
module dtag_lru_dec #(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS*WAY_W-1:0]     field_i,
  output logic [WAYS-1:0][WAY_W-1:0] way_o
);
  for (genvar k = 0; k < WAYS; k++) begin : g_way
    assign way_o[k] = field_i[k*WAY_W +: WAY_W];
  end
endmodule

// File: rtl/dtag_check.sv
module dtag_check
  import dtag_pkg::*;
#(
  parameter int TH_W     = 32,
  parameter int TL_W     = 64,
  parameter int IDX_W    = 13,
  parameter int PA_W     = 40,
  parameter int WAYS     = 4,
  parameter int ST_LSB   = 25,
  parameter int ST_W     = 5,
  parameter int LRU_LSB  = 14,
  parameter int PAR_SPLIT = 26,
  parameter int SET_LSB  = 6,
  parameter int SET_W    = 6,
  parameter int BANK_LO  = 5,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int LRU_W   = WAYS * WAY_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [TH_W-1:0]       tag_hi_i,
  input  logic [TL_W-1:0]       tag_lo_i,
  input  logic [IDX_W-1:0]      set_addr_i,
  output logic                  valid_o,
  output logic                  state_err_o,
  output logic                  addr_err_o,
  output logic [2:0]            state_o,
  output logic [PA_W-1:0]       paddr_o,
  output logic [LRU_W-1:0]      lru_way_o,
  output logic [1:0]            bank_o,
  output logic [SET_W-1:0]      set_o
);
  dst_e                       code;
  logic                       legal, mism_hi, mism_lo;
  logic [WAYS-1:0][WAY_W-1:0] ways;

  dtag_state_dec #(.ST_W(ST_W)) u_state (
    .st_i    (tag_hi_i[ST_LSB +: ST_W]),
    .code_o  (code),
    .legal_o (legal)
  );

  dtag_parity #(
    .TL_W(TL_W), .HI_MSB(PA_W-1), .SPLIT(PAR_SPLIT), .LO_LSB(IDX_W),
    .P1_BIT(11), .P0_BIT(10)
  ) u_par (
    .tag_lo_i  (tag_lo_i),
    .mism_hi_o (mism_hi),
    .mism_lo_o (mism_lo)
  );

  dtag_lru_dec #(.WAYS(WAYS), .WAY_W(WAY_W)) u_lru (
    .field_i (tag_hi_i[LRU_LSB +: LRU_W]),
    .way_o   (ways)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      state_err_o <= 1'b0;
      addr_err_o  <= 1'b0;
      state_o     <= '0;
      paddr_o     <= '0;
      lru_way_o   <= '0;
      bank_o      <= '0;
      set_o       <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        state_err_o <= ~legal;
        addr_err_o  <= legal & (mism_hi | mism_lo); // skipped on bad state
        state_o     <= code;
        paddr_o     <= {tag_lo_i[PA_W-1:IDX_W], set_addr_i};
        lru_way_o   <= ways;
        bank_o      <= {set_addr_i[IDX_W-1], set_addr_i[BANK_LO]};
        set_o       <= set_addr_i[SET_LSB +: SET_W];
      end
    end
  end

  // R4: illegal state never reports an address error
  assert_no_addr_on_bad_state_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_err_o |-> !addr_err_o);

  // R3: state error and illegal code agree
  assert_bad_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_err_o == (state_o == 3'(DST_BAD)));

  assert_one_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_no_spurious_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(paddr_o) && $stable(state_o) && $stable(lru_way_o)
                  && $stable(addr_err_o) && $stable(state_err_o)));
endmodule

// File: tb/dtag_check_bench.sv
`timescale 1ns/1ps
module dtag_check_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] tag_hi_i = '0;
  logic [63:0] tag_lo_i = '0;
  logic [12:0] set_addr_i = '0;
  logic        valid_o, state_err_o, addr_err_o;
  logic [2:0]  state_o;
  logic [39:0] paddr_o;
  logic [7:0]  lru_way_o;
  logic [1:0]  bank_o;
  logic [5:0]  set_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  dtag_check u_dtag_check (
    .clk_i, .rst_ni, .valid_i, .tag_hi_i, .tag_lo_i, .set_addr_i,
    .valid_o, .state_err_o, .addr_err_o, .state_o, .paddr_o,
    .lru_way_o, .bank_o, .set_o
  );

  typedef struct packed {
    logic [4:0]  st;
    logic [26:0] ptag;
    logic        f1;
    logic        f0;
    logic [12:0] set;
    logic [7:0]  lru;
    logic [2:0]  code;
    logic        serr;
    logic        aerr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{5'h00, 27'h5A5A5A5, 1'b0, 1'b0, 13'h1FE0, 8'hE4, 3'd0, 1'b0, 1'b0}, // R2
    '{5'h0F, 27'h0000001, 1'b0, 1'b0, 13'h0020, 8'h1B, 3'd1, 1'b0, 1'b0}, // R2
    '{5'h13, 27'h7FFFFFF, 1'b0, 1'b0, 13'h1000, 8'h4E, 3'd2, 1'b0, 1'b0}, // R2
    '{5'h19, 27'h2468ACE, 1'b0, 1'b0, 13'h0FC0, 8'hB1, 3'd3, 1'b0, 1'b0}, // R2
    '{5'h16, 27'h1357BDF, 1'b0, 1'b0, 13'h0A40, 8'h93, 3'd4, 1'b0, 1'b0}, // R2
    '{5'h1C, 27'h4000000, 1'b0, 1'b0, 13'h1060, 8'h6C, 3'd5, 1'b0, 1'b0}, // R2
    '{5'h1C, 27'h3C3C3C3, 1'b1, 1'b0, 13'h00A0, 8'hD8, 3'd5, 1'b0, 1'b1}, // R5
    '{5'h0F, 27'h0F0F0F0, 1'b0, 1'b1, 13'h1540, 8'h27, 3'd1, 1'b0, 1'b1}, // R6
    '{5'h13, 27'h6666666, 1'b1, 1'b1, 13'h0140, 8'h8D, 3'd2, 1'b0, 1'b1}, // R5 R6
    '{5'h1F, 27'h1111111, 1'b1, 1'b1, 13'h1FE0, 8'h72, 3'd7, 1'b1, 1'b0}, // R3 R4
    '{5'h01, 27'h0ABCDEF, 1'b0, 1'b0, 13'h0000, 8'h39, 3'd7, 1'b1, 1'b0}, // R3
    '{5'h12, 27'h5555555, 1'b1, 1'b0, 13'h0860, 8'hC6, 3'd7, 1'b1, 1'b0}  // R3 R4
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_lo(input logic [26:0] ptag, input logic f1, input logic f0);
    logic [63:0] t;
    t = 64'hA5C3_F000_0000_0000;
    t[39:13] = ptag;
    t[12] = 1'b1;
    t[11] = (^ptag[26:13]) ^ f1;
    t[10] = (^ptag[12:0]) ^ f0;
    t[9:0] = 10'h2B6;
    return t;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [39:0] held;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 valid", valid_o, 0);
    chk("R1 errs", {state_err_o, addr_err_o}, 0);
    chk("R1 state", state_o, 0);
    chk("R1 paddr", paddr_o, 0);
    chk("R1 lru/bank/set", {lru_way_o, bank_o, set_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      tag_hi_i = 32'h8000_0000 | (32'(VEC[i].st) << 25) | (32'(VEC[i].lru) << 14) | 32'h0000_3A5F;
      tag_lo_i = mk_lo(VEC[i].ptag, VEC[i].f1, VEC[i].f0);
      set_addr_i = VEC[i].set;
      valid_i = 1'b1;
      @(negedge clk_i);
      valid_i = 1'b0;
      chk("R10 valid_o", valid_o, 1);
      chk("R2/R3 state_o", state_o, VEC[i].code);
      chk("R3 state_err", state_err_o, VEC[i].serr);
      chk("R4/R5/R6 addr_err", addr_err_o, VEC[i].aerr);
      chk("R7 paddr", paddr_o, {VEC[i].ptag, VEC[i].set});
      for (int k = 0; k < 4; k++)
        chk("R8 lru way", lru_way_o[2*k +: 2], VEC[i].lru[2*k +: 2]);
      chk("R9 bank", bank_o, {VEC[i].set[12], VEC[i].set[5]});
      chk("R9 set", set_o, VEC[i].set[11:6]);
      @(negedge clk_i);
      chk("R10 single pulse", valid_o, 0);
    end

    // R11: inputs change with no strobe, outputs hold
    held = paddr_o;
    tag_hi_i = 32'h3E00_0000;
    tag_lo_i = '1;
    set_addr_i = 13'h1ABC;
    repeat (3) @(negedge clk_i);
    chk("R11 paddr hold", paddr_o, held);
    chk("R11 state hold", {state_o, state_err_o, addr_err_o}, {3'd7, 1'b1, 1'b0});
    chk("R11 valid low", valid_o, 0);

    // R1: reset in mid-run clears results
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 reset clears", {state_err_o, paddr_o, state_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule